// File: doc/BRIEF.md
# Aligned DMA Write Packer with Tail Residue

This block sits between a peripheral that delivers 16-bit words one at a time and a memory port that only accepts whole, naturally aligned 8-byte blocks. Software starts a transfer by giving it a start address and a 64-bit image of the memory block that holds that address. The address is rounded down to a block boundary, and its lane bits pick which 16-bit lane of the holding register the first incoming word lands in. Lanes below that point keep the preloaded memory bytes, so the first block written back merges old memory contents with the head of the stream.

Each time the top lane of the holding register is filled, the block is offered to memory with a request/acknowledge handshake. After the acknowledge, the block pointer moves up by one block and filling starts again at lane 0. A stop input ends the transfer. A block that is only partly filled is never written. It stays in the holding register, and the block address and the number of valid lanes remain visible, so software can merge the tail into memory itself.

Top module: `dmaPacker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, memReq, inReady and doneOut are 0, and memAddr, memData and residueCount are 0.
- R2: When cfgLoad is accepted, the block pointer becomes cfgAddr with bits [2:0] cleared, the fill lane becomes cfgAddr[2:1], and the holding register takes cfgPreload. cfgAddr[0] must be 0.
- R3: Accepted words fill the holding register in little-endian lane order. Lane i occupies bits [16i+15:16i]. Lanes below the start lane keep their preloaded value in the first block.
- R4: The cycle after the word that fills lane 3 is accepted, memReq is 1. memAddr is then the 8-byte-aligned block address and memData is the complete block. inReady is 0 while memReq is 1.
- R5: memReq, memAddr and memData stay stable until memAck. On memAck the pointer advances by 8, and in the next cycle the block accepts words again starting at lane 0.
- R6: A stop while words are streaming moves the block to the done state on the next cycle. Stop takes priority over a word offered in the same cycle: inReady is 0 while stopIn is 1, and that word is not taken.
- R7: A stop that arrives while a write is pending lets that write complete. The block enters the done state right after memAck and does not return to streaming.
- R8: In the done state, residueCount gives the number of valid lanes (0 to 3, counting preloaded lanes below the start), and memAddr gives the address of the unfinished block. memData holds the partial block. None of these change until the next cfgLoad, and the partial block is never written.
- R9: cfgLoad is accepted only in the idle or done state. While streaming or while a write is pending, it has no effect on the pointer, the lanes or the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Start strobe; captures the address and preload |
| cfgAddr | input | 32 | Start byte address (must be 16-bit aligned) |
| cfgPreload | input | 64 | Current memory contents of the starting block |
| inValid | input | 1 | Peripheral word valid |
| inData | input | 16 | Peripheral word |
| inReady | output | 1 | Word taken at the clock edge when inValid is also 1 |
| stopIn | input | 1 | Ends the transfer |
| memReq | output | 1 | Block write request |
| memAddr | output | 32 | Current block pointer; the write address while memReq is 1 |
| memData | output | 64 | Holding register; the write data while memReq is 1 |
| memAck | input | 1 | Memory accepts the pending block |
| doneOut | output | 1 | Transfer stopped; residue is readable |
| residueCount | output | 2 | Current fill lane; the valid chunk count when done |

## Verification
Assertions check the handshake rules on every cycle. Each one is tied to a requirement:
- A pending request and its address and data stay stable until acknowledged (R5).
- The pointer advances by exactly one block per acknowledge (R5).
- Words are never taken while a write is pending (R4).
- A stop while streaming moves the block to done on the next cycle (R6).
- Pointer, data and count stay frozen while done (R8).
- The start address is word aligned (R2).

The bench's scenarios exercise the rest: lane steering from each start offset, merging of preloaded lanes, residue counts and pointers after stops at different fill levels, a stop that lands during a pending write, and a cfgLoad ignored in mid-stream. A reference model is compared against the design on every cycle.

// File: rtl/dmaPackPkg.sv
package dmaPackPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STREAM = 2'd1,
    ST_FLUSH  = 2'd2,
    ST_HALT   = 2'd3
  } packStateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture start address and preload
    logic take;     // write incoming word into current lane
    logic advance;  // block accepted by memory, bump pointer
  } packStrobeT;

endpackage

// File: rtl/packData.sv
module packData
  import dmaPackPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  packStrobeT              strobe,
  input  logic [ADDR_W-1:0]       cfgAddr,
  input  logic [WORD_W*LANES-1:0] cfgPreload,
  input  logic [WORD_W-1:0]       inData,
  output logic [WORD_W*LANES-1:0] holdFlat,
  output logic [ADDR_W-1:0]       ptrReg,
  output logic [$clog2(LANES)-1:0] laneIdx,
  output logic                    laneLast
);
  localparam int BLOCK_W     = WORD_W * LANES;
  localparam int BLOCK_BYTES = BLOCK_W / 8;
  localparam int LANE_W      = $clog2(LANES);
  localparam int OFF_W       = $clog2(BLOCK_BYTES);
  localparam int WORD_OFF    = $clog2(WORD_W / 8);

  logic [WORD_W-1:0] laneReg [LANES];

  // One register per lane; the lane selector steers the incoming word
  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        laneReg[g] <= '0;
      end else if (strobe.load) begin
        laneReg[g] <= cfgPreload[g*WORD_W +: WORD_W];
      end else if (strobe.take && laneIdx == LANE_W'(g)) begin
        laneReg[g] <= inData;
      end
    end
    assign holdFlat[g*WORD_W +: WORD_W] = laneReg[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrReg  <= '0;
      laneIdx <= '0;
    end else if (strobe.load) begin
      ptrReg  <= {cfgAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      laneIdx <= cfgAddr[OFF_W-1 -: LANE_W];
    end else begin
      if (strobe.take)    laneIdx <= laneIdx + LANE_W'(1);
      if (strobe.advance) ptrReg  <= ptrReg + ADDR_W'(BLOCK_BYTES);
    end
  end

  assign laneLast = (laneIdx == LANE_W'(LANES - 1));

  // R2: start address must be word aligned
  assert_start_word_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> cfgAddr[WORD_OFF-1:0] == '0);

  // R5: each accepted block moves the pointer by exactly one block
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> ptrReg == $past(ptrReg) + ADDR_W'(BLOCK_BYTES));

endmodule

// File: rtl/packCtrl.sv
module packCtrl
  import dmaPackPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgLoad,
  input  logic       inValid,
  input  logic       stopIn,
  input  logic       memAck,
  input  logic       laneLast,
  output packStrobeT strobe,
  output logic       inReady,
  output logic       memReq,
  output logic       doneOut
);
  packStateT state, stateNext;
  logic      stopPend, stopPendNext;

  always_comb begin
    strobe.load    = cfgLoad && (state == ST_IDLE || state == ST_HALT);
    strobe.take    = (state == ST_STREAM) && inValid && !stopIn;
    strobe.advance = (state == ST_FLUSH) && memAck;
  end

  assign inReady = (state == ST_STREAM) && !stopIn;
  assign memReq  = (state == ST_FLUSH);
  assign doneOut = (state == ST_HALT);

  always_comb begin
    stateNext    = state;
    stopPendNext = stopPend;
    unique case (state)
      ST_IDLE, ST_HALT: begin
        if (strobe.load) begin
          stateNext    = ST_STREAM;
          stopPendNext = 1'b0;
        end
      end
      ST_STREAM: begin
        if (stopIn)                       stateNext = ST_HALT;
        else if (strobe.take && laneLast) stateNext = ST_FLUSH;
      end
      ST_FLUSH: begin
        if (stopIn) stopPendNext = 1'b1;
        if (memAck) begin
          stateNext    = (stopPend || stopIn) ? ST_HALT : ST_STREAM;
          stopPendNext = 1'b0;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stopPend <= 1'b0;
    end else begin
      state    <= stateNext;
      stopPend <= stopPendNext;
    end
  end

  // R4: no word is taken while a block write is pending
  assert_no_take_in_flush_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && inReady));

  // R5: request persists until acknowledged
  assert_req_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq);

  // R6: stop while streaming halts on the next cycle
  assert_stop_halts_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STREAM) && stopIn |=> doneOut);

endmodule

// File: rtl/dmaPacker.sv
module dmaPacker
  import dmaPackPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgLoad,
  input  logic [ADDR_W-1:0]        cfgAddr,
  input  logic [WORD_W*LANES-1:0]  cfgPreload,
  input  logic                     inValid,
  input  logic [WORD_W-1:0]        inData,
  output logic                     inReady,
  input  logic                     stopIn,
  output logic                     memReq,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [WORD_W*LANES-1:0]  memData,
  input  logic                     memAck,
  output logic                     doneOut,
  output logic [$clog2(LANES)-1:0] residueCount
);
  packStrobeT strobe;
  logic       laneLast;

  packCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgLoad  (cfgLoad),
    .inValid  (inValid),
    .stopIn   (stopIn),
    .memAck   (memAck),
    .laneLast (laneLast),
    .strobe   (strobe),
    .inReady  (inReady),
    .memReq   (memReq),
    .doneOut  (doneOut)
  );

  packData #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .LANES  (LANES)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgAddr    (cfgAddr),
    .cfgPreload (cfgPreload),
    .inData     (inData),
    .holdFlat   (memData),
    .ptrReg     (memAddr),
    .laneIdx    (residueCount),
    .laneLast   (laneLast)
  );

  // R5: pending write content does not move before the acknowledge
  assert_req_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr) && $stable(memData));

  // R8: residue state is frozen while done and not reloaded
  assert_residue_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneOut && !cfgLoad |=> doneOut && $stable(memAddr) && $stable(memData)
                            && $stable(residueCount));

endmodule

// File: tb/sim_dmaPacker.sv
`timescale 1ns/1ps
module sim_dmaPacker;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [31:0] cfgAddr = '0;
  logic [63:0] cfgPreload = '0;
  logic        inValid = 1'b0;
  logic [15:0] inData = '0;
  logic        inReady;
  logic        stopIn = 1'b0;
  logic        memReq;
  logic [31:0] memAddr;
  logic [63:0] memData;
  logic        memAck = 1'b0;
  logic        doneOut;
  logic [1:0]  residueCount;

  int checks = 0;
  int errors = 0;
  int writes = 0;
  int ackDly = 0;
  bit modelOn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmaPacker u0 (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgAddr(cfgAddr),
    .cfgPreload(cfgPreload), .inValid(inValid), .inData(inData),
    .inReady(inReady), .stopIn(stopIn), .memReq(memReq), .memAddr(memAddr),
    .memData(memData), .memAck(memAck), .doneOut(doneOut),
    .residueCount(residueCount)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model (behavioural) ----------------
  int          mState = 0;   // 0 idle, 1 streaming, 2 write pending, 3 done
  logic [31:0] mPtr = '0;
  logic [63:0] mHold = '0;
  int          mPos = 0;
  bit          mStopLate = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mPtr = '0; mHold = '0; mPos = 0; mStopLate = 1'b0;
    end else begin
      case (mState)
        0, 3: if (cfgLoad) begin
          mPtr = cfgAddr & ~32'd7;
          mPos = (cfgAddr >> 1) & 3;
          mHold = cfgPreload;
          mState = 1;
          mStopLate = 1'b0;
        end
        1: if (stopIn) mState = 3;
           else if (inValid) begin
             mHold[mPos*16 +: 16] = inData;
             if (mPos == 3) begin mPos = 0; mState = 2; end
             else mPos++;
           end
        2: begin
          if (stopIn) mStopLate = 1'b1;
          if (memAck) begin
            mPtr = mPtr + 8;
            mState = mStopLate ? 3 : 1;
            mStopLate = 1'b0;
          end
        end
        default: mState = 0;
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (modelOn) begin
      chk(memReq == (mState == 2), "R4 memReq", memReq, mState == 2);
      chk(inReady == (mState == 1 && !stopIn), "R6 inReady", inReady, mState == 1 && !stopIn);
      chk(doneOut == (mState == 3), "R8 doneOut", doneOut, mState == 3);
      chk(memAddr == mPtr, "R5 memAddr", memAddr, mPtr);
      chk(memData == mHold, "R3 memData", memData, mHold);
      chk(residueCount == 2'(mPos), "R8 residueCount", residueCount, mPos);
    end
    if (memReq && memAck) writes++;
  end

  // memory side: acknowledge after ackDly waiting cycles
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk); #1;
      if (memAck) memAck = 1'b0;
      else if (memReq) begin
        if (cnt >= ackDly) begin memAck = 1'b1; cnt = 0; end
        else cnt++;
      end
    end
  end

  // one transfer: start, stream n words, stop, then check the residue
  task automatic runXfer(input logic [31:0] addr, input logic [63:0] pre,
                         input int n, input int dly, input bit stopInFlush,
                         input bit midLoad);
    int startLane;
    int w;
    int wrBefore;
    int idle;
    startLane = (addr >> 1) & 3;
    ackDly = dly;
    wrBefore = writes;
    @(posedge clk); #1;
    cfgLoad = 1'b1; cfgAddr = addr; cfgPreload = pre;
    @(posedge clk); #1;
    cfgLoad = 1'b0;
    w = 0;
    while (w < n) begin
      inValid = 1'b1;
      inData = 16'(addr[15:0] ^ (16'h1111 * 16'(w + 1)));
      if (midLoad && w == 1) begin   // R9: load attempt while busy
        cfgLoad = 1'b1; cfgAddr = 32'h0000_FFF8; cfgPreload = ~pre;
      end
      @(negedge clk);
      if (inReady) w++;
      @(posedge clk); #1;
      cfgLoad = 1'b0;
      inValid = 1'b0;
      if (w % 3 == 2) begin @(posedge clk); #1; end
    end
    if (stopInFlush) begin
      idle = 0;
      while (!memReq && idle < 20) begin @(posedge clk); #1; idle++; end
      chk(memReq, "R7 write pending before stop", memReq, 1);
    end
    stopIn = 1'b1;
    inValid = 1'b1;                  // R6: word offered with stop must be dropped
    inData = 16'hDEAD;
    @(posedge clk); #1;
    stopIn = 1'b0;
    inValid = 1'b0;
    idle = 0;
    while (!doneOut && idle < 50) begin @(posedge clk); #1; idle++; end
    @(negedge clk);
    chk(doneOut, "R7 done reached", doneOut, 1);
    chk(residueCount == 2'((startLane + n) % 4), "R8 residue count",
        residueCount, (startLane + n) % 4);
    chk(memAddr == (addr & ~32'd7) + 32'(8 * ((startLane + n) / 4)),
        "R8 residue pointer", memAddr, (addr & ~32'd7) + 8 * ((startLane + n) / 4));
    chk(writes - wrBefore == (startLane + n) / 4, "R8 whole blocks only",
        writes - wrBefore, (startLane + n) / 4);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(doneOut && residueCount == 2'((startLane + n) % 4), "R8 frozen",
        residueCount, (startLane + n) % 4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!memReq && !inReady && !doneOut, "R1 reset controls", {memReq, inReady, doneOut}, 0);
    chk(memAddr == 0 && memData == 0 && residueCount == 0, "R1 reset data", memData, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    modelOn = 1'b1;
    @(negedge clk);
    chk(!memReq && !inReady && !doneOut, "R1 idle after reset", {memReq, inReady, doneOut}, 0);

    // R2 R3 R4: aligned start, two full blocks, immediate ack
    runXfer(32'h0000_1000, 64'hA0A1_A2A3_A4A5_A6A7, 8, 0, 1'b0, 1'b0);
    // R3: start at lane 3, preloaded lanes 0..2 kept, one word residue
    runXfer(32'h0000_2006, 64'h1122_3344_5566_7788, 6, 2, 1'b0, 1'b0);
    // R8: partial only, no writes, start lane 1
    runXfer(32'h0000_3002, 64'hCAFE_F00D_BEEF_0123, 2, 0, 1'b0, 1'b0);
    // R7: stop during pending write with slow ack
    runXfer(32'h0000_4004, 64'h0F0F_0F0F_F0F0_F0F0, 2, 3, 1'b1, 1'b0);
    // R9: load attempt mid-stream ignored
    runXfer(32'h0000_5002, 64'h1357_9BDF_2468_ACE0, 9, 1, 1'b0, 1'b1);
    // R6: stop right after load, nothing streamed
    runXfer(32'h0000_6004, 64'h7777_6666_5555_4444, 0, 0, 1'b0, 1'b0);

    repeat (4) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule